// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Generator

This block is a clocked digital oscillator that drives the two gates of a half-bridge. Each internal period (a "half-period", one half of a switching cycle) is counted in system clocks. A phase bit toggles at every half-period boundary, so the two gates take turns and the switching rate is half the internal rate. The last part of every half-period is a blanking interval in which both gates are low. Only the gate that owns the current half-period may go high, and only in the part before the blanking.

The half-period length comes from a feedback command word. Below a dead-zone threshold the command has no effect and the length sits at the longest setting, which is the minimum frequency. Above the threshold each extra command step shortens the half-period by one clock, down to the shortest setting, which is the maximum frequency. A soft-start ramp can be armed. It begins at the shortest length and grows by a fixed step at every half-period load. The length in use is the shorter of the ramp and the feedback value, which is the higher frequency. Length and dead time are captured only when a half-period begins.

All pins are plain control and status signals. There is no streamed data, so no valid/ready handshake and no back-pressure. Inputs are sampled at every clock edge.

Top module: `hb_gate_gen`

## Requirements
- R1: While reset is asserted, and while `en` is low after reset, `gate_lo` and `gate_hi` are both 0.
- R2: `gate_lo` and `gate_hi` are never high in the same cycle.
- R3: The first half-period after `en` rises always belongs to the low side (`gate_lo`). Side encoding: 0 = low side, 1 = high side.
- R4: In each half-period of length L with captured dead time D, the owning gate is high for L-D cycles and then both gates are low for D cycles. Sides alternate at every half-period.
- R5: The dead time is the `dead_cnt` value, clamped to L, and it is independent of the command. It shows as the low gap between consecutive pulses.
- R6: A command below DEAD_ZONE (default 16) gives L = PER_MAX (default 80).
- R7: L never goes below PER_MIN (default 8) or above PER_MAX. Large commands give PER_MIN.
- R8: Within range, L = PER_MAX - (fb_cmd - DEAD_ZONE).
- R9: A one-cycle `ss_req` pulse arms the ramp at PER_MIN. The k-th half-period loaded after that (k from 0) uses min(PER_MIN + k*RAMP_STEP (default 8), PER_MAX, feedback L).
- R10: Changes to `fb_cmd` or `dead_cnt` during a half-period take effect only from the next half-period.
- R11: When `en` is low at a clock edge, both gates are low after that edge. A restart begins on the low side.
- R12: With a steady command, both sides get equal high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops switching |
| ss_req | input | 1 | Arms the soft-start ramp at the shortest half-period |
| fb_cmd | input | CMD_W | Feedback frequency command; higher gives a shorter half-period |
| dead_cnt | input | DT_W | Blanking clocks at the end of each half-period |
| gate_lo | output | 1 | Low-side gate drive |
| gate_hi | output | 1 | High-side gate drive |

## Verification
The gates respond to `en` one clock edge after it is sampled. A command or dead-time change is seen only at the next half-period boundary, which is up to PER_MAX clocks later. Because of this, the scoreboard does not compare gates at fixed cycles. It measures each pulse as a record of side, high-time and the low gap before it, and compares that record with one predicted from the requirements. Stimulus changes come one nanosecond after a falling edge, and samples are taken on falling edges. Each run is stopped inside a blanking interval of at least two clocks, so no truncated pulse is ever counted.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic {
    SIDE_LO = 1'b0,
    SIDE_HI = 1'b1
  } side_e;
endpackage

// File: rtl/hbg_cmd_map.sv
module hbg_cmd_map #(
  parameter int CMD_W     = 8,
  parameter int LEN_W     = 7,
  parameter int PER_MIN   = 8,
  parameter int PER_MAX   = 80,
  parameter int DEAD_ZONE = 16
) (
  input  logic [CMD_W-1:0] fb_cmd,
  output logic [LEN_W-1:0] fb_len
);
  localparam int SPAN = PER_MAX - PER_MIN;

  logic [CMD_W-1:0] excess;

  always_comb begin
    excess = fb_cmd - CMD_W'(DEAD_ZONE);
    if (32'(fb_cmd) < DEAD_ZONE)
      fb_len = LEN_W'(PER_MAX);
    else if (32'(excess) >= SPAN)
      fb_len = LEN_W'(PER_MIN);
    else
      fb_len = LEN_W'(PER_MAX - 32'(excess));
  end
endmodule

// File: rtl/hbg_ramp.sv
module hbg_ramp #(
  parameter int LEN_W   = 7,
  parameter int PER_MIN = 8,
  parameter int PER_MAX = 80,
  parameter int STEP    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ss_req,
  input  logic             advance,
  output logic [LEN_W-1:0] ramp_len
);
  logic [LEN_W-1:0] ramp_q;
  logic [31:0]      grown;

  assign grown    = 32'(ramp_q) + STEP;
  assign ramp_len = ramp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ramp_q <= LEN_W'(PER_MAX);
    else if (ss_req)
      ramp_q <= LEN_W'(PER_MIN);
    else if (advance)
      ramp_q <= (grown >= PER_MAX) ? LEN_W'(PER_MAX) : LEN_W'(grown);
  end
endmodule

// File: rtl/hbg_core.sv
module hbg_core
  import hbg_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int DT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] len_in,
  input  logic [DT_W-1:0]  dead_in,
  output logic             gate_lo,
  output logic             gate_hi,
  output logic             running,
  output logic             load,
  output logic             boundary,
  output logic [LEN_W-1:0] len_cur
);
  logic             running_q;
  side_e            phase_q;
  logic [LEN_W-1:0] cnt_q, len_q, dt_q, dt_eff;
  logic             active;

  always_comb begin
    if (32'(dead_in) > 32'(len_in))
      dt_eff = len_in;
    else
      dt_eff = LEN_W'(dead_in);
  end

  assign boundary = running_q && (cnt_q == len_q - LEN_W'(1));
  assign load     = en && (!running_q || boundary);
  assign active   = running_q && (cnt_q < len_q - dt_q);
  assign gate_lo  = active && (phase_q == SIDE_LO);
  assign gate_hi  = active && (phase_q == SIDE_HI);
  assign running  = running_q;
  assign len_cur  = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      phase_q   <= SIDE_LO;
      cnt_q     <= '0;
      len_q     <= '0;
      dt_q      <= '0;
    end else if (!en) begin
      running_q <= 1'b0;
      phase_q   <= SIDE_LO;
      cnt_q     <= '0;
    end else if (load) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
      len_q     <= len_in;
      dt_q      <= dt_eff;
      if (!running_q)
        phase_q <= SIDE_LO;
      else
        phase_q <= (phase_q == SIDE_LO) ? SIDE_HI : SIDE_LO;
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/hb_gate_gen.sv
module hb_gate_gen #(
  parameter int CMD_W     = 8,
  parameter int DT_W      = 7,
  parameter int PER_MIN   = 8,
  parameter int PER_MAX   = 80,
  parameter int DEAD_ZONE = 16,
  parameter int RAMP_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ss_req,
  input  logic [CMD_W-1:0] fb_cmd,
  input  logic [DT_W-1:0]  dead_cnt,
  output logic             gate_lo,
  output logic             gate_hi
);
  localparam int LEN_W = $clog2(PER_MAX + 1);

  logic [LEN_W-1:0] fb_len, ramp_len, eff_len, len_q;
  logic             running, load, boundary;

  assign eff_len = (ramp_len < fb_len) ? ramp_len : fb_len;

  hbg_cmd_map #(
    .CMD_W(CMD_W), .LEN_W(LEN_W), .PER_MIN(PER_MIN),
    .PER_MAX(PER_MAX), .DEAD_ZONE(DEAD_ZONE)
  ) u_map (
    .fb_cmd (fb_cmd),
    .fb_len (fb_len)
  );

  hbg_ramp #(
    .LEN_W(LEN_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .STEP(RAMP_STEP)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ss_req   (ss_req),
    .advance  (load),
    .ramp_len (ramp_len)
  );

  hbg_core #(
    .LEN_W(LEN_W), .DT_W(DT_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .len_in   (eff_len),
    .dead_in  (dead_cnt),
    .gate_lo  (gate_lo),
    .gate_hi  (gate_hi),
    .running  (running),
    .load     (load),
    .boundary (boundary),
    .len_cur  (len_q)
  );
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk #(
  parameter int LEN_W   = 7,
  parameter int PER_MIN = 8,
  parameter int PER_MAX = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             gate_lo,
  input logic             gate_hi,
  input logic             running,
  input logic             boundary,
  input logic [LEN_W-1:0] len_q
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi)); // R2

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> !gate_hi); // R3

  AST_LEN_IN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (32'(len_q) >= PER_MIN && 32'(len_q) <= PER_MAX)); // R7

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && en && !boundary) |=> $stable(len_q)); // R10

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_lo && !gate_hi)); // R11
endmodule

bind hb_gate_gen hbg_chk #(
  .LEN_W(LEN_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .gate_lo  (gate_lo),
  .gate_hi  (gate_hi),
  .running  (running),
  .boundary (boundary),
  .len_q    (len_q)
);

// File: tb/sim_hb_gate_gen.sv
`timescale 1ns/1ps
module sim_hb_gate_gen;
  localparam int P_MIN = 8, P_MAX = 80, DZ = 16, STEP = 8;

  typedef struct {
    bit    side;
    int    on;
    int    pre;
    string tag;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, ss_req = 1'b0;
  logic [7:0] fb_cmd = '0;
  logic [6:0] dead_cnt = '0;
  logic       gate_lo, gate_hi;

  int   errors = 0, checks = 0, rcvd = 0;
  bit   skip = 1'b0, overlap_seen = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  hb_gate_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_req(ss_req),
    .fb_cmd(fb_cmd), .dead_cnt(dead_cnt),
    .gate_lo(gate_lo), .gate_hi(gate_hi)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fb_len(int cmd);
    if (cmd < DZ) return P_MAX;
    if (cmd - DZ >= P_MAX - P_MIN) return P_MIN;
    return P_MAX - (cmd - DZ);
  endfunction

  // driver side of the scoreboard: predicted pulse records
  task automatic plan(int n, bit ss, int ca, int da, int cb, int db,
                      int nsw, string tag);
    int prev_dt = -1;
    for (int k = 0; k < n; k++) begin
      int c, d, len, r, dt;
      exp_t e;
      c   = (k < nsw) ? ca : cb;
      d   = (k < nsw) ? da : db;
      len = fb_len(c);
      r   = ss ? P_MIN + STEP * k : P_MAX;
      if (r > P_MAX) r = P_MAX;
      if (r < len) len = r;
      dt  = (d > len) ? len : d;
      e.side = bit'(k % 2);
      e.on   = len - dt;
      e.pre  = prev_dt;
      e.tag  = tag;
      q.push_back(e);
      prev_dt = dt;
    end
  endtask

  task automatic run(int n, int ca, int da, bit chg, int cb, int db);
    int target = rcvd + n;
    fb_cmd   = 8'(ca);
    dead_cnt = 7'(da);
    en = 1'b1;
    if (chg) begin
      while (!gate_lo) @(negedge clk);
      repeat (2) @(negedge clk);
      #1;
      fb_cmd   = 8'(cb);
      dead_cnt = 7'(db);
    end
    while (rcvd < target) @(negedge clk);
    #1 en = 1'b0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R4 all predicted pulses seen", q.size(), 0);
  endtask

  // monitor side: measure each pulse, pop and compare
  bit in_pulse = 0, have_prev = 0, cur_side = 0;
  int on_len = 0, gap = 0, pre_gap = -1;
  always @(negedge clk) begin
    if (gate_lo && gate_hi) overlap_seen = 1'b1;
    if (!en) begin
      in_pulse  = 0;
      have_prev = 0;
      gap       = 0;
    end else if (gate_lo || gate_hi) begin
      if (!in_pulse) begin
        in_pulse = 1;
        on_len   = 1;
        cur_side = gate_hi;
        pre_gap  = have_prev ? gap : -1;
      end else begin
        on_len++;
      end
    end else if (in_pulse) begin
      in_pulse  = 0;
      have_prev = 1;
      gap       = 1;
      if (!skip) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected pulse", on_len, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cur_side == e.side, {e.tag, " side"}, cur_side, e.side);
          check(on_len == e.on, {e.tag, " high time"}, on_len, e.on);
          check(pre_gap == e.pre, {e.tag, " dead gap"}, pre_gap, e.pre);
        end
        rcvd++;
      end
    end else if (have_prev) begin
      gap++;
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!gate_lo && !gate_hi, "R1 gates low in reset", gate_lo | gate_hi, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!gate_lo && !gate_hi, "R1 gates low while disabled",
          gate_lo | gate_hi, 0);

    // dead zone: minimum frequency
    plan(4, 0, 5, 3, 5, 3, 4, "R6 R4 R5");
    run(4, 5, 3, 0, 0, 0);
    // linear range, symmetric halves
    plan(4, 0, 56, 10, 56, 10, 4, "R8 R12 R5");
    run(4, 56, 10, 0, 0, 0);
    // clamp at maximum frequency
    plan(4, 0, 200, 2, 200, 2, 4, "R7 R4");
    run(4, 200, 2, 0, 0, 0);
    // soft-start ramp hands over to feedback
    @(negedge clk); #1 ss_req = 1'b1;
    @(negedge clk); #1 ss_req = 1'b0;
    plan(10, 1, 40, 2, 40, 2, 10, "R9");
    run(10, 40, 2, 0, 0, 0);
    // mid-period change waits for the boundary
    plan(4, 0, 56, 4, 36, 6, 1, "R10");
    run(4, 56, 4, 1, 36, 6);

    // disable in the middle of a pulse
    skip     = 1'b1;
    fb_cmd   = 8'd56;
    dead_cnt = 7'd3;
    en       = 1'b1;
    while (!gate_lo) @(negedge clk);
    repeat (3) @(negedge clk);
    #1 en = 1'b0;
    @(negedge clk);
    check(!gate_lo && !gate_hi, "R11 gates low one edge after disable",
          gate_lo | gate_hi, 0);
    repeat (3) @(negedge clk);
    #1 skip = 1'b0;
    // restart resumes on the low side
    plan(2, 0, 56, 3, 56, 3, 2, "R11 R3");
    run(2, 56, 3, 0, 0, 0);

    check(!overlap_seen, "R2 no overlap observed", overlap_seen, 0);
    report();
    $finish;
  end
endmodule